// File: doc/BRIEF.md
# Flash Command Decoder with Status

This block is the command state machine of a nibble-paired flash memory. The host writes command bytes through a write strobe; the decoder turns them into program, sector erase, erase-verify, attribute-space, identification and abort actions. Program and erase each need a setup byte followed by a second write, so a single stray write can never change the array. Once a program or erase has started, an internal timer paced by an external timebase tick ends it, and a ready flag stays low for the whole operation.

While an operation runs, reads do not return plain array data. A read of the location being written returns the complement of the written value on the top bit of each nibble, and the bit below the top of each nibble toggles on every read. Outside that, reads return array data, identification codes or margin-read data depending on the mode. The array is external: the decoder issues one-cycle program and erase requests and takes read data back on an input.

The write strobe passes through a synchronous pulse-width filter, so a strobe that is low for fewer than a set number of clock cycles is dropped. A permission input, driven low by the surrounding protection logic, blocks every write.

Top module: `flash_cmd_decoder`

## Requirements
- R1: After code 11h, the next accepted write issues exactly one `arr_prog` pulse carrying that write's address and data, and `ready` stays low until PROG_TICKS timebase pulses have elapsed.
- R2: Code 22h followed by code DDh issues one `arr_erase` pulse at the DDh write's address; `ready` stays low until ERASE_TICKS timebase pulses elapse or code FFh is written.
- R3: Code FFh written after either setup code issues no array request, leaves `ready` high and returns to read mode, where reads return `arr_rdata`.
- R4: Code 88h drives `attr_sel` high whatever the level of `attr_pin`, and only code FFh clears it; with the mode off, `attr_sel` follows `attr_pin`.
- R5: After code 99h, a read of address 0 returns BFh, address 1 returns 11h and any other address returns 00h; code FFh or another command leaves this mode.
- R6: While busy, a read of the address being written returns bit 7 and bit 3 as the complement of the written data's bits 7 and 3 (all-ones data for an erase).
- R7: While busy, bits 6 and 2 of every read are equal, read 0 on the first read after the operation starts and invert on each further read; after completion reads return `arr_rdata` again.
- R8: A write strobe held low for fewer than MIN_LOW clock cycles is ignored.
- R9: A write made while `wr_allow` is low is ignored.
- R10: While busy, every command other than FFh is ignored.
- R11: Code AAh raises `margin_rd`, which falls after the next read.
- R12: After reset, `ready` is high, `margin_rd` is low, `rdata` is 00h, no request is issued and `attr_sel` equals `attr_pin`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_n | input | 1 | Write strobe, active low; the write takes effect when it returns high |
| rd_en | input | 1 | One-cycle read request; `rdata` is valid the next cycle |
| addr | input | ADDR_W | Address for reads and writes |
| wdata | input | DATA_W | Write data (command or program data) |
| wr_allow | input | 1 | High when writes are permitted by protection logic |
| attr_pin | input | 1 | External attribute-space select |
| tick | input | 1 | Timebase pulse for the operation timer |
| arr_rdata | input | DATA_W | Read data from the array |
| rdata | output | DATA_W | Registered read data |
| ready | output | 1 | High when no program or erase is running |
| attr_sel | output | 1 | Attribute space selected |
| margin_rd | output | 1 | Erase-verify margin read pending |
| arr_prog | output | 1 | One-cycle program request |
| arr_erase | output | 1 | One-cycle sector erase request |
| arr_addr | output | ADDR_W | Address of the array request |
| arr_data | output | DATA_W | Data of the program request |

## Verification
The checker watches on every cycle that each array request is a single pulse, that it only follows a cycle with `ready` high and `wr_allow` high, and that `ready` is low whenever a request is issued. The setup/execute ordering, the abort paths, the identification codes, the polling and toggle bit values, the glitch filter and the timer length depend on sequences of writes and reads, so only the bench scenarios show them, comparing `rdata`, `ready`, `attr_sel` and counted requests against values worked out from the requirements.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

   typedef enum logic [2:0] {
      ST_READ,
      ST_IDENT,
      ST_PSETUP,
      ST_ESETUP,
      ST_VERIFY,
      ST_PBUSY,
      ST_EBUSY
   } fcd_state_e;

   localparam logic [7:0] CMD_PROG_SETUP  = 8'h11;
   localparam logic [7:0] CMD_ERASE_SETUP = 8'h22;
   localparam logic [7:0] CMD_ERASE_GO    = 8'hDD;
   localparam logic [7:0] CMD_ABORT       = 8'hFF;
   localparam logic [7:0] CMD_ATTR        = 8'h88;
   localparam logic [7:0] CMD_IDENT       = 8'h99;
   localparam logic [7:0] CMD_VERIFY      = 8'hAA;

   localparam logic [7:0] ID_MAKER  = 8'hBF;
   localparam logic [7:0] ID_DEVICE = 8'h11;

endpackage

// File: rtl/fcd_strobe_filter.sv
module fcd_strobe_filter #(
   parameter int ADDR_W  = 20,
   parameter int DATA_W  = 8,
   parameter int MIN_LOW = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              stb,
   output logic [ADDR_W-1:0] stb_addr,
   output logic [DATA_W-1:0] stb_data
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stb_addr <= '0;
         stb_data <= '0;
      end else if (!wr_n) begin
         stb_addr <= addr;
         stb_data <= wdata;
      end
   end

   generate
      if (MIN_LOW == 1) begin : g_edge
         logic low_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_q <= 1'b0;
               stb   <= 1'b0;
            end else begin
               low_q <= !wr_n;
               stb   <= wr_n && low_q;
            end
         end
      end else begin : g_count
         localparam int CW = $clog2(MIN_LOW + 1);
         localparam logic [CW-1:0] FULL = CW'(MIN_LOW);
         logic [CW-1:0] low_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               low_cnt <= '0;
               stb     <= 1'b0;
            end else begin
               stb <= wr_n && (low_cnt == FULL);
               if (wr_n)
                  low_cnt <= '0;
               else if (low_cnt != FULL)
                  low_cnt <= low_cnt + 1'b1;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/fcd_op_timer.sv
module fcd_op_timer #(
   parameter int PROG_TICKS  = 4,
   parameter int ERASE_TICKS = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic is_erase,
   input  logic tick,
   output logic done
);

   localparam int MAXT = (PROG_TICKS > ERASE_TICKS) ? PROG_TICKS : ERASE_TICKS;
   localparam int TW   = $clog2(MAXT + 1);
   localparam logic [TW-1:0] P_LAST = TW'(PROG_TICKS - 1);
   localparam logic [TW-1:0] E_LAST = TW'(ERASE_TICKS - 1);

   logic [TW-1:0] tcnt;
   logic [TW-1:0] last;

   assign last = is_erase ? E_LAST : P_LAST;
   assign done = run && tick && (tcnt == last);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         tcnt <= '0;
      else if (!run)
         tcnt <= '0;
      else if (tick)
         tcnt <= tcnt + 1'b1;
   end

endmodule

// File: rtl/fcd_read_mux.sv
module fcd_read_mux
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W = 20,
   parameter int DATA_W = 8
) (
   input  fcd_state_e        st,
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] op_addr,
   input  logic [DATA_W-1:0] op_data,
   input  logic [DATA_W-1:0] arr_rdata,
   input  logic              tog,
   output logic [DATA_W-1:0] rd_val
);

   logic hit;
   assign hit = (addr == op_addr);

   always_comb begin
      rd_val = arr_rdata;
      unique case (st)
         ST_IDENT: begin
            if (addr == '0)
               rd_val = ID_MAKER;
            else if (addr == ADDR_W'(1))
               rd_val = ID_DEVICE;
            else
               rd_val = '0;
         end
         ST_PBUSY, ST_EBUSY: begin
            if (hit) begin
               rd_val[7] = ~op_data[7];
               rd_val[3] = ~op_data[3];
            end
            rd_val[6] = tog;
            rd_val[2] = tog;
         end
         default: rd_val = arr_rdata;
      endcase
   end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
   import flash_cmd_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int DATA_W      = 8,
   parameter int MIN_LOW     = 3,
   parameter int PROG_TICKS  = 4,
   parameter int ERASE_TICKS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              wr_allow,
   input  logic              attr_pin,
   input  logic              tick,
   input  logic [DATA_W-1:0] arr_rdata,
   output logic [DATA_W-1:0] rdata,
   output logic              ready,
   output logic              attr_sel,
   output logic              margin_rd,
   output logic              arr_prog,
   output logic              arr_erase,
   output logic [ADDR_W-1:0] arr_addr,
   output logic [DATA_W-1:0] arr_data
);

   generate
      if (DATA_W != 8) begin : g_bad_width
         $error("flash_cmd_decoder: DATA_W must be 8");
      end
      if (MIN_LOW < 1) begin : g_bad_low
         $error("flash_cmd_decoder: MIN_LOW must be at least 1");
      end
      if (PROG_TICKS < 1 || ERASE_TICKS < 1) begin : g_bad_ticks
         $error("flash_cmd_decoder: tick counts must be at least 1");
      end
   endgenerate

   fcd_state_e        st;
   logic              stb;
   logic [ADDR_W-1:0] w_addr;
   logic [DATA_W-1:0] w_data;
   logic              acc;
   logic              busy;
   logic              tm_done;
   logic              attr_q;
   logic              tog;
   logic [ADDR_W-1:0] op_addr;
   logic [DATA_W-1:0] op_data;
   logic [DATA_W-1:0] rd_val;

   fcd_strobe_filter #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W),
      .MIN_LOW(MIN_LOW)
   ) u_filt (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_n    (wr_n),
      .addr    (addr),
      .wdata   (wdata),
      .stb     (stb),
      .stb_addr(w_addr),
      .stb_data(w_data)
   );

   assign busy = (st == ST_PBUSY) || (st == ST_EBUSY);
   assign acc  = stb && wr_allow;

   fcd_op_timer #(
      .PROG_TICKS (PROG_TICKS),
      .ERASE_TICKS(ERASE_TICKS)
   ) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (busy),
      .is_erase(st == ST_EBUSY),
      .tick    (tick),
      .done    (tm_done)
   );

   fcd_read_mux #(
      .ADDR_W(ADDR_W),
      .DATA_W(DATA_W)
   ) u_rmux (
      .st       (st),
      .addr     (addr),
      .op_addr  (op_addr),
      .op_data  (op_data),
      .arr_rdata(arr_rdata),
      .tog      (tog),
      .rd_val   (rd_val)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= ST_READ;
         attr_q    <= 1'b0;
         tog       <= 1'b0;
         rdata     <= '0;
         op_addr   <= '0;
         op_data   <= '0;
         arr_prog  <= 1'b0;
         arr_erase <= 1'b0;
         arr_addr  <= '0;
         arr_data  <= '0;
      end else begin
         arr_prog  <= 1'b0;
         arr_erase <= 1'b0;

         if (rd_en) begin
            rdata <= rd_val;
            if (busy)
               tog <= ~tog;
            if (st == ST_VERIFY)
               st <= ST_READ;
         end

         if (busy && tm_done)
            st <= ST_READ;

         if (acc) begin
            unique case (st)
               ST_PSETUP: begin
                  if (w_data == CMD_ABORT) begin
                     st     <= ST_READ;
                     attr_q <= 1'b0;
                  end else begin
                     st       <= ST_PBUSY;
                     tog      <= 1'b0;
                     op_addr  <= w_addr;
                     op_data  <= w_data;
                     arr_prog <= 1'b1;
                     arr_addr <= w_addr;
                     arr_data <= w_data;
                  end
               end
               ST_ESETUP: begin
                  if (w_data == CMD_ERASE_GO) begin
                     st        <= ST_EBUSY;
                     tog       <= 1'b0;
                     op_addr   <= w_addr;
                     op_data   <= '1;
                     arr_erase <= 1'b1;
                     arr_addr  <= w_addr;
                  end else begin
                     st <= ST_READ;
                     if (w_data == CMD_ABORT)
                        attr_q <= 1'b0;
                  end
               end
               ST_PBUSY, ST_EBUSY: begin
                  if (w_data == CMD_ABORT) begin
                     st     <= ST_READ;
                     attr_q <= 1'b0;
                  end
               end
               default: begin
                  unique case (w_data)
                     CMD_PROG_SETUP:  st <= ST_PSETUP;
                     CMD_ERASE_SETUP: st <= ST_ESETUP;
                     CMD_IDENT:       st <= ST_IDENT;
                     CMD_VERIFY:      st <= ST_VERIFY;
                     CMD_ATTR: begin
                        st     <= ST_READ;
                        attr_q <= 1'b1;
                     end
                     CMD_ABORT: begin
                        st     <= ST_READ;
                        attr_q <= 1'b0;
                     end
                     default: ;
                  endcase
               end
            endcase
         end
      end
   end

   assign ready     = !busy;
   assign attr_sel  = attr_q || attr_pin;
   assign margin_rd = (st == ST_VERIFY);

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker (
   input logic clk,
   input logic rst_n,
   input logic wr_allow,
   input logic ready,
   input logic arr_prog,
   input logic arr_erase
);

   AST_PROG_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_prog |-> !ready) else $error("program request without busy"); // R1

   AST_ERASE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      arr_erase |-> !ready) else $error("erase request without busy"); // R2

   AST_SINGLE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_prog || arr_erase) |=> !(arr_prog || arr_erase)) else $error("request longer than one cycle"); // R1

   AST_WR_PERMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_prog || arr_erase) |-> $past(wr_allow)) else $error("request while writes blocked"); // R9

   AST_REQ_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (arr_prog || arr_erase) |-> $past(ready)) else $error("request accepted while busy"); // R10

   AST_ONE_KIND: assert property (@(posedge clk) disable iff (!rst_n)
      !(arr_prog && arr_erase)) else $error("program and erase together"); // R2

endmodule

bind flash_cmd_decoder fcd_checker u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_allow (wr_allow),
   .ready    (ready),
   .arr_prog (arr_prog),
   .arr_erase(arr_erase)
);

// File: tb/flash_cmd_decoder_tb.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb;

   localparam int AW = 20;
   localparam int DW = 8;
   localparam int ML = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          wr_n = 1'b1;
   logic          rd_en = 1'b0;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] wdata = '0;
   logic          wr_allow = 1'b1;
   logic          attr_pin = 1'b0;
   logic          tick = 1'b0;
   logic [DW-1:0] arr_rdata;
   logic [DW-1:0] rdata;
   logic          ready, attr_sel, margin_rd, arr_prog, arr_erase;
   logic [AW-1:0] arr_addr;
   logic [DW-1:0] arr_data;

   int n_tests = 0;
   int n_fail  = 0;
   int n_prog  = 0;
   int n_erase = 0;
   logic [AW-1:0] seen_addr = '0;
   logic [DW-1:0] seen_data = '0;
   logic finished = 1'b0;

   always #2 clk = ~clk;

   assign arr_rdata = addr[7:0] ^ 8'h5A;

   flash_cmd_decoder #(.ADDR_W(AW), .DATA_W(DW), .MIN_LOW(ML),
                       .PROG_TICKS(4), .ERASE_TICKS(8)) u_dut (
      .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .wr_allow(wr_allow), .attr_pin(attr_pin), .tick(tick),
      .arr_rdata(arr_rdata), .rdata(rdata), .ready(ready), .attr_sel(attr_sel),
      .margin_rd(margin_rd), .arr_prog(arr_prog), .arr_erase(arr_erase),
      .arr_addr(arr_addr), .arr_data(arr_data));

   always @(posedge clk) begin
      if (arr_prog) begin
         n_prog++;
         seen_addr <= arr_addr;
         seen_data <= arr_data;
      end
      if (arr_erase) begin
         n_erase++;
         seen_addr <= arr_addr;
      end
   end

   initial begin
      forever begin
         repeat (3) @(negedge clk);
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
      end
   end

   // is_read, addr, data, expected read value
   localparam logic [36:0] VEC [0:8] = '{
      {1'b1, 20'h00010, 8'h00, 8'h4A},
      {1'b0, 20'h00000, 8'h99, 8'h00},
      {1'b1, 20'h00000, 8'h00, 8'hBF},
      {1'b1, 20'h00001, 8'h00, 8'h11},
      {1'b1, 20'h00002, 8'h00, 8'h00},
      {1'b0, 20'h00000, 8'hFF, 8'h00},
      {1'b1, 20'h00001, 8'h00, 8'h5B},
      {1'b0, 20'h00000, 8'h88, 8'h00},
      {1'b1, 20'h00003, 8'h00, 8'h59}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d, input int lowc = ML);
      @(negedge clk);
      addr = a; wdata = d; wr_n = 1'b0;
      repeat (lowc) @(negedge clk);
      wr_n = 1'b1;
      repeat (3) @(negedge clk);
   endtask

   task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] v);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      @(negedge clk);
      rd_en = 1'b0;
      v = rdata;
   endtask

   task automatic wait_ready(output int cyc);
      cyc = 0;
      while (!ready && cyc < 1000) begin
         @(negedge clk);
         cyc++;
      end
   endtask

   function automatic logic [7:0] busy_val(input logic [7:0] arr, input logic [7:0] d,
                                           input logic hit, input logic t);
      logic [7:0] v = arr;
      if (hit) begin v[7] = ~d[7]; v[3] = ~d[3]; end
      v[6] = t; v[2] = t;
      return v;
   endfunction

   initial begin
      logic [7:0] v;
      int cyc;
      int p0;
      repeat (3) @(negedge clk);
      // R12 reset state
      chk("R12 ready", ready, 1);
      chk("R12 rdata", rdata, 0);
      chk("R12 margin", margin_rd, 0);
      chk("R12 attr", attr_sel, 0);
      rst_n = 1'b1;
      @(negedge clk);
      attr_pin = 1'b1; @(negedge clk);
      chk("R4 pin drives attr", attr_sel, 1);
      attr_pin = 1'b0; @(negedge clk);

      // table: R5 ident codes, R3 read mode data, R4 attr mode
      for (int i = 0; i < 9; i++) begin
         if (VEC[i][36]) begin
            rd(VEC[i][35:16], v);
            chk($sformatf("R5 table read %0d", i), v, VEC[i][7:0]);
         end else begin
            wr(VEC[i][35:16], VEC[i][15:8]);
         end
      end
      chk("R4 attr set by 88h", attr_sel, 1);
      attr_pin = 1'b1; @(negedge clk); attr_pin = 1'b0; @(negedge clk);
      chk("R4 attr held after pin toggles", attr_sel, 1);
      wr(0, 8'hFF);
      chk("R4 attr cleared by FFh", attr_sel, 0);

      // R1 program
      wr(0, 8'h11);
      wr(20'h00123, 8'h3C);
      chk("R1 one program request", n_prog, 1);
      chk("R1 program addr", seen_addr, 20'h00123);
      chk("R1 program data", seen_data, 8'h3C);
      chk("R1 busy", ready, 0);
      rd(20'h00123, v);
      chk("R6 R7 first busy read", v, busy_val(8'h79, 8'h3C, 1'b1, 1'b0));
      rd(20'h00123, v);
      chk("R7 second busy read toggles", v, busy_val(8'h79, 8'h3C, 1'b1, 1'b1));
      rd(20'h00050, v);
      chk("R7 other address toggles", v, busy_val(8'h0A, 8'h3C, 1'b0, 1'b0));
      wr(0, 8'h99);
      chk("R10 busy ignores command", ready, 0);
      wait_ready(cyc);
      chk("R1 program completes", ready, 1);
      rd(20'h00000, v);
      chk("R10 ident not entered", v, 8'h5A);
      rd(20'h00123, v);
      chk("R7 toggling stopped", v, 8'h79);
      rd(20'h00123, v);
      chk("R7 stable after done", v, 8'h79);

      // R2 erase aborted by FFh
      wr(0, 8'h22);
      wr(20'h00400, 8'hDD);
      chk("R2 one erase request", n_erase, 1);
      chk("R2 erase addr", seen_addr, 20'h00400);
      chk("R2 busy", ready, 0);
      rd(20'h00400, v);
      chk("R6 erase poll", v, busy_val(8'h5A, 8'hFF, 1'b1, 1'b0));
      wr(0, 8'hFF);
      chk("R2 reset ends erase", ready, 1);

      // R2 erase ends on timer
      wr(0, 8'h22);
      wr(20'h00800, 8'hDD);
      chk("R2 second erase", n_erase, 2);
      wait_ready(cyc);
      chk("R2 erase timer ends", ready, 1);
      chk("R2 erase lasted ticks", cyc > 20, 1);

      // R3 aborts
      p0 = n_prog;
      wr(0, 8'h11);
      wr(0, 8'hFF);
      chk("R3 abort program ready", ready, 1);
      wr(20'h00007, 8'h55);
      chk("R3 no program after abort", n_prog, p0);
      wr(0, 8'h22);
      wr(0, 8'hFF);
      chk("R3 abort erase", n_erase, 2);
      rd(20'h00004, v);
      chk("R3 read mode data", v, 8'h5E);

      // R11 erase verify
      wr(0, 8'hAA);
      chk("R11 margin set", margin_rd, 1);
      rd(20'h00002, v);
      chk("R11 margin read data", v, 8'h58);
      chk("R11 margin cleared", margin_rd, 0);

      // R8 short strobe, R9 blocked write
      wr(0, 8'h88, ML - 1);
      chk("R8 short strobe ignored", attr_sel, 0);
      wr_allow = 1'b0;
      wr(0, 8'h88);
      chk("R9 blocked write ignored", attr_sel, 0);
      wr(0, 8'h11);
      wr(20'h00009, 8'h01);
      wr_allow = 1'b1;
      chk("R9 no program when blocked", n_prog, p0);
      wr(0, 8'h88);
      chk("R8 full strobe accepted", attr_sel, 1);

      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

endmodule